// File: doc/BRIEF.md
# Peripheral Interrupt Aggregator With Wakeup

This block gathers up to 96 peripheral interrupt request lines, organised as three banks of 32, and folds them onto the seven general-purpose core event levels 7 to 13. Each request is sampled once per clock into a status bank, which software can read to find out which peripheral on a shared level is asking for service. A per-source mask bank decides which sampled requests reach the core levels. Several sources share each level through a fixed mapping.

The core's pending vector is fed back as the acknowledgement. While the core reports a level as pending, that level's output is held low. When the core leaves the handler, any source still active on the shared level raises the line again, so the core sees a fresh rising edge. A separate per-source wakeup-enable bank drives a wakeup output while the core reports idle. This wakeup path ignores the mask bank.

Top module: `sys_irq_agg`

## Requirements
- R1: After reset the mask and wakeup-enable banks are all zero, and `core_lvl_o` and `wake_o` are low.
- R2: A write with `reg_wr` high stores `reg_wdata` on the rising edge. `reg_addr[3:2]` selects the kind (0 = mask, 1 = status, 2 = wakeup enable) and `reg_addr[1:0]` selects the bank (0..2). Reads on `reg_rdata` are combinational.
- R3: The status bank for a bank reads back the value `irq_i` held at the previous rising edge, with bank b bit i being source 32*b+i. Writes to status are ignored.
- R4: Bit j of `core_lvl_o` stands for core level 7+j. It is high when any source mapped to that level is set in both status and mask. The mapping is: sources 0–7 to level 7, 8–15 to level 8, 16–23 to level 9, 24–47 to level 10, 48–63 to level 11, 64–71 to level 12, and 72–95 to level 13.
- R5: A source whose mask bit is clear has no effect on `core_lvl_o`.
- R6: While `ipend_i[7+j]` is high, `core_lvl_o[j]` is low. Once that bit clears, the output follows R4 again in the same cycle.
- R7: `wake_o` is high when `idle_i` is high and any source is set in both status and wakeup enable, whatever its mask bit.
- R8: `wake_o` is low whenever `idle_i` is low.
- R9: Reads of a bank index of 3 or a kind of 3 return zero. Writes to those addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | 96 | Peripheral request levels |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register kind and bank select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data |
| ipend_i | input | 16 | Core pending vector (acknowledgement) |
| idle_i | input | 1 | Core idle or asleep |
| core_lvl_o | output | 7 | Requests to core levels 7..13 |
| wake_o | output | 1 | Wakeup request |

## Verification
A request change on `irq_i` is due in status, `core_lvl_o` and `wake_o` one rising edge later. The bench drives inputs on the falling edge and checks on the next falling edge. Register writes take effect at the edge that captures them, and reads are combinational, so readback is sampled shortly after the address is set. Changes to `ipend_i` and `idle_i` reach the outputs without a clock, so those checks are made in the same half-cycle, after a short settling delay.

// File: rtl/sys_irq_agg.sv
module sys_irq_agg #(
  parameter int NBANK  = 3,
  parameter int BANK_W = 32,
  parameter int LVL_LO = 7,
  parameter int LVL_HI = 13
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NBANK*BANK_W-1:0] irq_i,
  input  logic                    reg_wr,
  input  logic [3:0]              reg_addr,
  input  logic [BANK_W-1:0]       reg_wdata,
  output logic [BANK_W-1:0]       reg_rdata,
  input  logic [15:0]             ipend_i,
  input  logic                    idle_i,
  output logic [LVL_HI-LVL_LO:0]  core_lvl_o,
  output logic                    wake_o
);
  localparam int NSRC = NBANK * BANK_W;
  localparam int NLVL = LVL_HI - LVL_LO + 1;

  logic [NSRC-1:0] mask_q, wen_q, st_q;
  logic [1:0] kind, bank;
  logic bank_ok;

  assign kind    = reg_addr[3:2];
  assign bank    = reg_addr[1:0];
  assign bank_ok = 32'(bank) < NBANK;

  function automatic int lvl_of(int s);
    if (s < 8)       return 0;
    else if (s < 16) return 1;
    else if (s < 24) return 2;
    else if (s < 48) return 3;
    else if (s < 64) return 4;
    else if (s < 72) return 5;
    else             return 6;
  endfunction

  function automatic logic [NSRC-1:0] lvl_sel(int l);
    logic [NSRC-1:0] v;
    v = '0;
    for (int s = 0; s < NSRC; s++) v[s] = (lvl_of(s) == l);
    return v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      wen_q  <= '0;
      st_q   <= '0;
    end else begin
      st_q <= irq_i;
      if (reg_wr && bank_ok) begin
        if (kind == 2'd0) mask_q[32'(bank)*BANK_W +: BANK_W] <= reg_wdata;
        if (kind == 2'd2) wen_q[32'(bank)*BANK_W +: BANK_W]  <= reg_wdata;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (bank_ok) begin
      case (kind)
        2'd0:    reg_rdata = mask_q[32'(bank)*BANK_W +: BANK_W];
        2'd1:    reg_rdata = st_q[32'(bank)*BANK_W +: BANK_W];
        2'd2:    reg_rdata = wen_q[32'(bank)*BANK_W +: BANK_W];
        default: reg_rdata = '0;
      endcase
    end
  end

  for (genvar l = 0; l < NLVL; l++) begin : g_lvl
    localparam logic [NSRC-1:0] SEL = lvl_sel(l);
    assign core_lvl_o[l] = (|(st_q & mask_q & SEL)) & ~ipend_i[LVL_LO+l];
  end

  assign wake_o = idle_i & (|(st_q & wen_q));
endmodule

module sys_irq_agg_chk #(
  parameter int NSRC = 96,
  parameter int NLVL = 7,
  parameter int LVL_LO = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] irq_i,
  input logic [NSRC-1:0] st_q,
  input logic [15:0]     ipend_i,
  input logic            idle_i,
  input logic [NLVL-1:0] core_lvl_o,
  input logic            wake_o
);
  always @(posedge clk) begin
    if (!rst_n) begin
      // R1
      reset_quiet_chk: assert (core_lvl_o == '0 && !wake_o);
    end
  end

  // R3
  status_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> st_q == $past(irq_i));

  // R6
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_lvl_o & ipend_i[LVL_LO +: NLVL]) == '0);

  // R8
  wake_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_i |-> !wake_o);

  // R7
  wake_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> st_q != '0);
endmodule

bind sys_irq_agg sys_irq_agg_chk #(.NSRC(NSRC), .NLVL(NLVL), .LVL_LO(LVL_LO)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .st_q(st_q), .ipend_i(ipend_i),
  .idle_i(idle_i), .core_lvl_o(core_lvl_o), .wake_o(wake_o)
);

// File: tb/tb_sys_irq_agg.sv
module tb_sys_irq_agg;
  logic clk = 0, rst_n = 0;
  logic [95:0] irq_i = '0;
  logic reg_wr = 0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [15:0] ipend_i = '0;
  logic idle_i = 0;
  logic [6:0] core_lvl_o;
  logic wake_o;
  int n_run = 0, n_fail = 0;

  sys_irq_agg dut (.*);

  always #5 clk = ~clk;

  function automatic int exp_lvl(int s);
    if (s < 8) return 0; if (s < 16) return 1; if (s < 24) return 2;
    if (s < 48) return 3; if (s < 64) return 4; if (s < 72) return 5;
    return 6;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic drive(logic [95:0] v);
    @(negedge clk); irq_i = v; @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int b = 0; b < 3; b++) begin
      rd(4'(b), d); chk("R1 mask", d, 0);
      rd(4'(8 + b), d); chk("R1 wen", d, 0);
    end
    chk("R1 lvl", 32'(core_lvl_o), 0);
    chk("R1 wake", 32'(wake_o), 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(4'd0, 32'h1234_5678); wr(4'd1 + 4'd0, 32'h0); wr(4'd2, 32'hA5A5_0F0F);
    wr(4'd9, 32'hDEAD_BEEF);
    rd(4'd0, d); chk("R2 mask0", d, 32'h1234_5678);
    rd(4'd1, d); chk("R2 mask1", d, 32'h0);
    rd(4'd2, d); chk("R2 mask2", d, 32'hA5A5_0F0F);
    rd(4'd9, d); chk("R2 wen1", d, 32'hDEAD_BEEF);
    wr(4'd3, 32'hFFFF_FFFF); wr(4'd12, 32'hFFFF_FFFF);
    rd(4'd3, d); chk("R9 bank3", d, 0);
    rd(4'd12, d); chk("R9 kind3", d, 0);
    rd(4'd0, d); chk("R9 mask0 kept", d, 32'h1234_5678);
    rd(4'd8, d); chk("R9 wen0 kept", d, 0);
    wr(4'd0, 0); wr(4'd2, 0); wr(4'd9, 0);
  endtask

  task automatic t_status();
    logic [31:0] d;
    drive({32'hCAFE_0001, 32'h8000_0000, 32'h0000_00F3});
    rd(4'd4, d); chk("R3 st0", d, 32'h0000_00F3);
    rd(4'd5, d); chk("R3 st1", d, 32'h8000_0000);
    rd(4'd6, d); chk("R3 st2", d, 32'hCAFE_0001);
    wr(4'd4, 32'h0);
    rd(4'd4, d); chk("R3 st ro", d, 32'h0000_00F3);
    chk("R5 masked", 32'(core_lvl_o), 0);
    drive('0);
  endtask

  task automatic t_map();
    int srcs[9] = '{0, 9, 23, 24, 47, 48, 70, 72, 95};
    wr(4'd0, '1); wr(4'd1, '1); wr(4'd2, '1);
    foreach (srcs[k]) begin
      logic [95:0] v = '0;
      v[srcs[k]] = 1'b1;
      drive(v);
      chk($sformatf("R4 src%0d", srcs[k]), 32'(core_lvl_o), 32'(1) << exp_lvl(srcs[k]));
    end
    drive((96'd1 << 3) | (96'd1 << 66));
    chk("R4 two", 32'(core_lvl_o), 32'h21);
    wr(4'd0, 32'hFFFF_FFF7);
    chk("R5 mask src3", 32'(core_lvl_o), 32'h20);
    drive('0);
  endtask

  task automatic t_ack();
    drive(96'd1 << 20);
    chk("R6 before", 32'(core_lvl_o), 32'h04);
    ipend_i[9] = 1; #1;
    chk("R6 held", 32'(core_lvl_o), 0);
    ipend_i[8] = 1; ipend_i[9] = 0; #1;
    chk("R6 rearm", 32'(core_lvl_o), 32'h04);
    ipend_i = '0;
    drive('0);
  endtask

  task automatic t_wake();
    wr(4'd0, 0); wr(4'd1, 0); wr(4'd2, 0);
    wr(4'd10, 32'h0000_0100);
    drive(96'd1 << 72);
    chk("R8 not idle", 32'(wake_o), 0);
    idle_i = 1; #1;
    chk("R7 wake unmasked-off", 32'(wake_o), 1);
    chk("R5 no lvl", 32'(core_lvl_o), 0);
    drive(96'd1 << 73);
    chk("R7 not enabled", 32'(wake_o), 0);
    idle_i = 0; drive('0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        t_regs(); t_status(); t_map(); t_ack(); t_wake();
      end
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule